// File: doc/BRIEF.md
# Single-Digit Decimal Adder

This block adds two decimal digits, each coded in four binary bits. It returns one corrected decimal digit and a decimal carry. There is no clock and no carry input. The result settles as a pure function of the two digit inputs. A multi-digit adder or a decimal arithmetic datapath uses it as the digit cell.

Internally the two digits are first added as plain 4-bit binary numbers, which gives a partial sum and a binary carry. A decimal overflow flag is then formed. When the flag is set, a short correction chain adds six to the partial sum. The chain acts on bits 1 to 3 only, because adding six never changes bit 0. The overflow flag itself is the decimal carry. The carry out of the correction chain is dropped.

Input codes 10 to 15 are outside the block's contract, and no behaviour is promised for them.

Top module: `bcd_digit_adder`

## Requirements
- R1: The partial sum is the low four bits of the binary sum a_i + b_i, and the binary carry is bit 4 of that sum.
- R2: cout_o is 1 exactly when the decimal sum a_i + b_i is 10 or more, and 0 otherwise.
- R3: When the decimal sum is 9 or less, s_o equals the binary sum a_i + b_i unchanged.
- R4: When the decimal sum is 10 or more, s_o equals (a_i + b_i + 6) mod 16, and the carry out of that correction is discarded.
- R5: s_o[0] always equals a_i[0] XOR b_i[0], because the correction never reaches bit 0.
- R6: For every pair of valid digits (0 to 9 each), cout_o equals (a_i + b_i) div 10 and s_o equals (a_i + b_i) mod 10, covering results 0 to 18.
- R7: For sums 16 to 18 the binary carry is set while the high-code term is clear, and cout_o is still 1. The overflow flag is the XOR of the two terms, and the two are never set together.
- R8: s_o is always a valid decimal digit (9 or less) for valid inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First decimal digit, coded 0 to 9 |
| b_i | input | 4 | Second decimal digit, coded 0 to 9 |
| s_o | output | 4 | Units digit of the decimal sum |
| cout_o | output | 1 | Tens digit of the decimal sum (0 or 1) |

## Verification
The hardest case to reach is a sum of 16 to 18. There the binary carry alone raises the overflow flag, the upper code bits are small, and the XOR form of the flag is actually exercised. Only six of the hundred digit pairs land there, so a random draw seldom hits them. The bench sweeps all hundred pairs exhaustively, adds directed hits on 9+9, 8+8 and 7+9, and then mixes in seeded random pairs.

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [3:0] s_o,
  output logic       cout_o
);

  logic [4:0] rc;
  logic [3:0] t;
  logic       c4;
  logic       hi_code;
  logic       ovf;
  logic       k1;
  logic       k2;
  logic       x2;

  assign rc[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_rip
      assign t[g]    = a_i[g] ^ b_i[g] ^ rc[g];
      assign rc[g+1] = (a_i[g] & b_i[g]) | ((a_i[g] ^ b_i[g]) & rc[g]);
    end
  endgenerate

  assign c4      = rc[4];
  assign hi_code = (t[2] | t[1]) & t[3];
  assign ovf     = hi_code ^ c4;

  assign s_o[0] = t[0];
  assign s_o[1] = t[1] ^ ovf;
  assign k1     = t[1] & ovf;
  assign x2     = t[2] ^ ovf;
  assign s_o[2] = x2 ^ k1;
  assign k2     = (x2 & k1) | (t[2] & ovf);
  assign s_o[3] = t[3] ^ k2;
  assign cout_o = ovf;

  logic [4:0] bin_sum;
  assign bin_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (a_i <= 4'd9 && b_i <= 4'd9) begin
      assert_carry_R2: assert (cout_o == (bin_sum > 5'd9));
      assert_terms_R7: assert (!(hi_code && c4));
      assert_digit_R8: assert (s_o <= 4'd9);
      assert_bit0_R5:  assert (s_o[0] == (a_i[0] ^ b_i[0]));
      if (bin_sum <= 5'd9) begin
        assert_pass_R3: assert (s_o == bin_sum[3:0]);
      end else begin
        assert_fix_R4: assert (s_o == bin_sum[3:0] + 4'd6);
      end
    end
  end

endmodule

// File: tb/bcd_digit_adder_bench.sv
module bcd_digit_adder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = 4'd0;
  logic [3:0] b = 4'd0;
  logic [3:0] s;
  logic       co;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_digit_adder u_bcd_digit_adder (.a_i(a), .b_i(b), .s_o(s), .cout_o(co));

  function automatic int exp_tens(int x, int y); return (x + y) / 10; endfunction
  function automatic int exp_units(int x, int y); return (x + y) % 10; endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(posedge clk);
    a = 4'(x);
    b = 4'(y);
    @(negedge clk);
    check("R6", {co, s}, {exp_tens(x, y) != 0, 4'(exp_units(x, y))});
    check("R2", co, (x + y) >= 10);
    check("R5", s[0], (x ^ y) & 1);
    check("R8", s <= 4'd9, 1);
    if (x + y <= 9) check("R3", s, x + y);
    else            check("R4", s, (x + y + 6) % 16);
    if (x + y >= 16) check("R7", co, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {co, s}, 0);
    apply(9, 9);
    apply(8, 8);
    apply(7, 9);
    apply(9, 0);
    apply(5, 5);
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        apply(i, j);
    void'($urandom(32'd2718));
    for (int k = 0; k < 200; k++)
      apply($urandom % 10, $urandom % 10);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule